// File: doc/BRIEF.md
# Memory Access Alignment Fault Checker

This block watches two request streams of a 64-bit processor core, the instruction fetch stream and the data access stream, and decides on each cycle whether either request breaks an alignment rule. It never rounds an address down to make it legal. Every violation is turned into a one-cycle fault pulse with a class code, and the offending address is captured for the exception handler. This is done because a misaligned program counter or stack pointer almost always means software state has been corrupted.

The rules depend on the request. A fetch must be word aligned. An access that uses the stack pointer as its base must start from a 16-byte aligned base, but only when the stack check is switched on for the current exception level. Exclusive and ordered accesses must be naturally aligned. Paired exclusive accesses must be aligned to twice the element size. Plain accesses are free of any alignment rule on normal memory, but must be naturally aligned on device memory. When several rules fail at once, a fixed priority picks the one that is reported.

Top module: `align_guard`

## Requirements
- R1: A fetch request (`fetch_valid`=1) whose `fetch_pc[1:0]` is not 2'b00 raises `fault` with `fault_class`=2'b01 on the next cycle. A fetch with `fetch_pc[1:0]`=2'b00 raises nothing.
- R2: On a PC fault, `fault_addr` and `link_addr` both take the complete 64-bit `fetch_pc`, with no bits cleared.
- R3: A data request with `data_sp_base`=1 whose `data_base[3:0]` is not 4'b0000 raises `fault_class`=2'b10 when the stack check is enabled for the current level. An aligned base, or `data_sp_base`=0, raises no SP fault.
- R4: The stack check enable is selected by `cur_el`: value 0 uses `sp_chk_el0`, 1 uses `sp_chk_el1`, 2 uses `sp_chk_el2` and 3 uses `sp_chk_el3`. A disabled level raises no SP fault.
- R5: `data_kind`=2'b01 (exclusive) must be naturally aligned. `data_size` encodes 0/1/2/3 as 1/2/4/8 bytes. A violation gives `fault_class`=2'b11.
- R6: `data_kind`=2'b10 (exclusive pair) must be aligned to twice the element size, so a pair of 8-byte elements needs 16-byte alignment. A violation gives 2'b11.
- R7: `data_kind`=2'b11 (ordered) must be naturally aligned. A violation gives 2'b11.
- R8: `data_kind`=2'b00 (plain) never faults on normal memory (`data_device`=0). On device memory (`data_device`=1) it must be naturally aligned, or 2'b11 is raised.
- R9: Priority is PC fault first, then SP fault, then the data misalignment fault. Only the winner is reported.
- R10: Outputs are registered and appear one cycle after the request, and `fault` is high only for that cycle. A data fault loads `data_addr` into `fault_addr` and leaves `link_addr` unchanged. Without a fault, both addresses hold their values. Requests with their valid low are ignored.
- R11: A synchronous reset (`rst`=1) clears `fault`, `fault_class`, `fault_addr` and `link_addr` to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| fetch_valid | input | 1 | Fetch request strobe |
| fetch_pc | input | 64 | Fetch program counter |
| data_valid | input | 1 | Data request strobe |
| data_base | input | 64 | Base register value of the data access |
| data_addr | input | 64 | Final data address |
| data_size | input | 2 | Element size, log2 of bytes |
| data_sp_base | input | 1 | Base register is the stack pointer |
| data_kind | input | 2 | 00 plain, 01 exclusive, 10 exclusive pair, 11 ordered |
| data_device | input | 1 | Target is device memory |
| cur_el | input | 2 | Current exception level |
| sp_chk_el0 | input | 1 | Stack check enable, level 0 |
| sp_chk_el1 | input | 1 | Stack check enable, level 1 |
| sp_chk_el2 | input | 1 | Stack check enable, level 2 |
| sp_chk_el3 | input | 1 | Stack check enable, level 3 |
| fault | output | 1 | One-cycle fault pulse |
| fault_class | output | 2 | 00 none, 01 PC, 10 SP, 11 data misaligned |
| fault_addr | output | 64 | Captured faulting address |
| link_addr | output | 64 | Captured faulting PC |

## Verification
A misaligned fetch and a faulting data access can land in the same cycle. The same is true of a stack-pointer fault and an exclusive, pair or ordered misalignment. The stimulus table holds vectors that assert these pairs together on one cycle. Each such vector is judged by checking that the class code names only the higher-priority fault. The bench also checks that the captured address comes from the port that won: the fetch PC when the fetch wins, the data address when the SP fault wins over an exclusive fault.

// File: rtl/align_guard.sv
module align_guard #(
  parameter int AW = 64
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          fetch_valid,
  input  logic [AW-1:0] fetch_pc,
  input  logic          data_valid,
  input  logic [AW-1:0] data_base,
  input  logic [AW-1:0] data_addr,
  input  logic [1:0]    data_size,
  input  logic          data_sp_base,
  input  logic [1:0]    data_kind,
  input  logic          data_device,
  input  logic [1:0]    cur_el,
  input  logic          sp_chk_el0,
  input  logic          sp_chk_el1,
  input  logic          sp_chk_el2,
  input  logic          sp_chk_el3,
  output logic          fault,
  output logic [1:0]    fault_class,
  output logic [AW-1:0] fault_addr,
  output logic [AW-1:0] link_addr
);

  localparam logic [1:0] K_PLAIN = 2'b00;
  localparam logic [1:0] K_EXCL  = 2'b01;
  localparam logic [1:0] K_PAIR  = 2'b10;
  localparam logic [1:0] K_ORD   = 2'b11;
  localparam logic [1:0] C_NONE  = 2'b00;
  localparam logic [1:0] C_PC    = 2'b01;
  localparam logic [1:0] C_SP    = 2'b10;
  localparam logic [1:0] C_DATA  = 2'b11;

  logic [3:0] sp_en;
  logic       sp_on, pc_bad, sp_bad, ea_bad, need_nat, need_pair;
  logic [3:0] nat_mask, pair_mask;
  logic [1:0] next_class;
  logic [1:0] class_q;

  assign sp_en = {sp_chk_el3, sp_chk_el2, sp_chk_el1, sp_chk_el0};
  assign sp_on = sp_en[cur_el];

  always_comb begin
    case (data_size)
      2'd0:    nat_mask = 4'b0000;
      2'd1:    nat_mask = 4'b0001;
      2'd2:    nat_mask = 4'b0011;
      default: nat_mask = 4'b0111;
    endcase
  end
  assign pair_mask = {nat_mask[2:0], 1'b1};

  assign need_nat  = (data_kind == K_EXCL) || (data_kind == K_ORD) ||
                     ((data_kind == K_PLAIN) && data_device);
  assign need_pair = (data_kind == K_PAIR);

  assign pc_bad = fetch_valid && (fetch_pc[1:0] != 2'b00);
  assign sp_bad = data_valid && data_sp_base && sp_on && (data_base[3:0] != 4'b0000);
  assign ea_bad = data_valid &&
                  ((need_nat  && ((data_addr[3:0] & nat_mask)  != 4'b0000)) ||
                   (need_pair && ((data_addr[3:0] & pair_mask) != 4'b0000)));

  assign next_class = pc_bad ? C_PC : sp_bad ? C_SP : ea_bad ? C_DATA : C_NONE;

  always_ff @(posedge clk) begin
    if (rst) begin
      class_q    <= C_NONE;
      fault_addr <= '0;
      link_addr  <= '0;
    end else begin
      class_q <= next_class;
      if (next_class != C_NONE)
        fault_addr <= pc_bad ? fetch_pc : data_addr;
      if (pc_bad)
        link_addr <= fetch_pc;
    end
  end

  assign fault       = (class_q != C_NONE);
  assign fault_class = class_q;

  a_r1_pc_fault: assert property (@(posedge clk) disable iff (rst)
    (fetch_valid && fetch_pc[1:0] != 2'b00) |=> (fault && fault_class == C_PC));

  a_r2_pc_capture: assert property (@(posedge clk) disable iff (rst)
    (fetch_valid && fetch_pc[1:0] != 2'b00) |=>
      (fault_addr == $past(fetch_pc) && link_addr == $past(fetch_pc)));

  // R3 and R4: enabled level, misaligned SP base, no fetch fault
  a_r3_sp_fault: assert property (@(posedge clk) disable iff (rst)
    (data_valid && data_sp_base && sp_en[cur_el] && data_base[3:0] != 4'b0000 &&
     !(fetch_valid && fetch_pc[1:0] != 2'b00)) |=> (fault_class == C_SP));

  a_r8_plain_normal_free: assert property (@(posedge clk) disable iff (rst)
    (data_valid && data_kind == K_PLAIN && !data_device && !data_sp_base && !fetch_valid)
      |=> !fault);

  a_r10_hold: assert property (@(posedge clk) disable iff (rst)
    !fault |-> ($stable(fault_addr) || $past(rst)));

  a_r10_link_hold: assert property (@(posedge clk) disable iff (rst)
    (fault_class != C_PC) |-> ($stable(link_addr) || $past(rst)));

  a_r10_idle: assert property (@(posedge clk) disable iff (rst)
    (!fetch_valid && !data_valid) |=> !fault);

endmodule

// File: tb/align_guard_bench.sv
`timescale 1ns/1ps
module align_guard_bench;

  typedef struct packed {
    logic       fv;
    logic [1:0] pclo;
    logic       dv;
    logic       sp;
    logic [1:0] kind;
    logic       dev;
    logic [1:0] size;
    logic [1:0] el;
    logic [3:0] en;
    logic [3:0] baselo;
    logic [3:0] addrlo;
    logic [1:0] exp;
    logic [3:0] rq;
  } vec_t;

  localparam int NV = 30;
  localparam vec_t VEC [NV] = '{
    '{1'b1,2'd2,1'b0,1'b0,2'b00,1'b0,2'd0,2'd0,4'b0000,4'h0,4'h0,2'b01,4'd1}, // R1 pc lo 10
    '{1'b1,2'd0,1'b0,1'b0,2'b00,1'b0,2'd0,2'd0,4'b0000,4'h0,4'h0,2'b00,4'd1}, // R1 aligned
    '{1'b1,2'd1,1'b0,1'b0,2'b00,1'b0,2'd0,2'd0,4'b0000,4'h0,4'h0,2'b01,4'd1}, // R1 pc lo 01
    '{1'b1,2'd3,1'b0,1'b0,2'b00,1'b0,2'd0,2'd0,4'b0000,4'h0,4'h0,2'b01,4'd2}, // R2 capture
    '{1'b0,2'd0,1'b1,1'b1,2'b00,1'b0,2'd3,2'd1,4'b0010,4'h8,4'h0,2'b10,4'd3}, // R3 el1 on
    '{1'b0,2'd0,1'b1,1'b1,2'b00,1'b0,2'd3,2'd1,4'b1101,4'h8,4'h0,2'b00,4'd4}, // R4 el1 off
    '{1'b0,2'd0,1'b1,1'b1,2'b00,1'b0,2'd3,2'd2,4'b1111,4'h0,4'h0,2'b00,4'd3}, // R3 aligned
    '{1'b0,2'd0,1'b1,1'b1,2'b00,1'b0,2'd3,2'd3,4'b1000,4'h4,4'h0,2'b10,4'd4}, // R4 el3 on
    '{1'b0,2'd0,1'b1,1'b1,2'b00,1'b0,2'd3,2'd0,4'b1110,4'h4,4'h0,2'b00,4'd4}, // R4 el0 off
    '{1'b0,2'd0,1'b1,1'b1,2'b00,1'b0,2'd3,2'd0,4'b0001,4'h1,4'h0,2'b10,4'd4}, // R4 el0 on
    '{1'b0,2'd0,1'b1,1'b0,2'b01,1'b0,2'd2,2'd0,4'b0000,4'h0,4'h4,2'b00,4'd5}, // R5
    '{1'b0,2'd0,1'b1,1'b0,2'b01,1'b0,2'd2,2'd0,4'b0000,4'h0,4'h2,2'b11,4'd5}, // R5
    '{1'b0,2'd0,1'b1,1'b0,2'b01,1'b0,2'd3,2'd0,4'b0000,4'h0,4'h8,2'b00,4'd5}, // R5
    '{1'b0,2'd0,1'b1,1'b0,2'b01,1'b0,2'd1,2'd0,4'b0000,4'h0,4'h1,2'b11,4'd5}, // R5
    '{1'b0,2'd0,1'b1,1'b0,2'b01,1'b0,2'd0,2'd0,4'b0000,4'h0,4'h3,2'b00,4'd5}, // R5 byte
    '{1'b0,2'd0,1'b1,1'b0,2'b01,1'b0,2'd3,2'd0,4'b0000,4'h0,4'h4,2'b11,4'd5}, // R5
    '{1'b0,2'd0,1'b1,1'b0,2'b10,1'b0,2'd3,2'd0,4'b0000,4'h0,4'h8,2'b11,4'd6}, // R6
    '{1'b0,2'd0,1'b1,1'b0,2'b10,1'b0,2'd3,2'd0,4'b0000,4'h0,4'h0,2'b00,4'd6}, // R6
    '{1'b0,2'd0,1'b1,1'b0,2'b10,1'b0,2'd2,2'd0,4'b0000,4'h0,4'h8,2'b00,4'd6}, // R6
    '{1'b0,2'd0,1'b1,1'b0,2'b10,1'b0,2'd2,2'd0,4'b0000,4'h0,4'h4,2'b11,4'd6}, // R6
    '{1'b0,2'd0,1'b1,1'b0,2'b11,1'b0,2'd3,2'd0,4'b0000,4'h0,4'h4,2'b11,4'd7}, // R7
    '{1'b0,2'd0,1'b1,1'b0,2'b11,1'b0,2'd1,2'd0,4'b0000,4'h0,4'h2,2'b00,4'd7}, // R7
    '{1'b0,2'd0,1'b1,1'b0,2'b00,1'b0,2'd3,2'd0,4'b0000,4'h0,4'h5,2'b00,4'd8}, // R8 normal
    '{1'b0,2'd0,1'b1,1'b0,2'b00,1'b1,2'd3,2'd0,4'b0000,4'h0,4'h5,2'b11,4'd8}, // R8 device
    '{1'b0,2'd0,1'b1,1'b0,2'b00,1'b1,2'd0,2'd0,4'b0000,4'h0,4'h5,2'b00,4'd8}, // R8 byte
    '{1'b0,2'd0,1'b1,1'b1,2'b01,1'b0,2'd3,2'd1,4'b1111,4'h8,4'h2,2'b10,4'd9}, // R9 SP>excl
    '{1'b1,2'd1,1'b1,1'b1,2'b00,1'b0,2'd3,2'd1,4'b1111,4'h8,4'h0,2'b01,4'd9}, // R9 PC>SP
    '{1'b0,2'd0,1'b1,1'b1,2'b10,1'b0,2'd3,2'd1,4'b1111,4'h0,4'h8,2'b11,4'd9}, // R9 aligned SP
    '{1'b0,2'd0,1'b0,1'b0,2'b01,1'b0,2'd3,2'd0,4'b0000,4'h0,4'h1,2'b00,4'd10}, // R10 no valid
    '{1'b0,2'd0,1'b1,1'b0,2'b00,1'b0,2'd3,2'd0,4'b1111,4'h4,4'h0,2'b00,4'd3}  // R3 not SP
  };

  logic        clk = 1'b0;
  logic        rst;
  logic        fetch_valid, data_valid, data_sp_base, data_device;
  logic        sp_chk_el0, sp_chk_el1, sp_chk_el2, sp_chk_el3;
  logic [63:0] fetch_pc, data_base, data_addr;
  logic [1:0]  data_size, data_kind, cur_el;
  logic        fault;
  logic [1:0]  fault_class;
  logic [63:0] fault_addr, link_addr;

  int errors = 0;
  int checks = 0;
  logic done = 1'b0;

  always #4 clk = ~clk;

  align_guard u_align_guard (
    .clk(clk), .rst(rst),
    .fetch_valid(fetch_valid), .fetch_pc(fetch_pc),
    .data_valid(data_valid), .data_base(data_base), .data_addr(data_addr),
    .data_size(data_size), .data_sp_base(data_sp_base), .data_kind(data_kind),
    .data_device(data_device), .cur_el(cur_el),
    .sp_chk_el0(sp_chk_el0), .sp_chk_el1(sp_chk_el1),
    .sp_chk_el2(sp_chk_el2), .sp_chk_el3(sp_chk_el3),
    .fault(fault), .fault_class(fault_class),
    .fault_addr(fault_addr), .link_addr(link_addr)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle();
    fetch_valid = 1'b0; data_valid = 1'b0; data_sp_base = 1'b0; data_device = 1'b0;
    data_kind = 2'b00; data_size = 2'd0; cur_el = 2'd0;
    sp_chk_el0 = 1'b0; sp_chk_el1 = 1'b0; sp_chk_el2 = 1'b0; sp_chk_el3 = 1'b0;
    fetch_pc = '0; data_base = '0; data_addr = '0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [63:0] exp_fa, exp_la;
    idle();
    rst = 1'b1;
    fetch_valid = 1'b1; fetch_pc = 64'h3;
    repeat (3) @(negedge clk);
    // R11: reset state, even with a misaligned fetch present
    chk("R11 fault", {63'b0, fault}, 64'h0);
    chk("R11 class", {62'b0, fault_class}, 64'h0);
    chk("R11 fault_addr", fault_addr, 64'h0);
    chk("R11 link_addr", link_addr, 64'h0);
    idle();
    rst = 1'b0;
    @(negedge clk);
    exp_fa = '0; exp_la = '0;

    for (int i = 0; i < NV; i++) begin
      logic [63:0] pc, ad, bs;
      pc = {48'hFFFF_8000_1000, 8'(i), 6'b0, VEC[i].pclo};
      ad = {48'h0000_7F00_2000, 8'(i), 4'h0, VEC[i].addrlo};
      bs = {48'h0000_7F00_3000, 8'(i), 4'h0, VEC[i].baselo};
      fetch_valid = VEC[i].fv; fetch_pc = pc;
      data_valid = VEC[i].dv; data_addr = ad; data_base = bs;
      data_sp_base = VEC[i].sp; data_kind = VEC[i].kind; data_device = VEC[i].dev;
      data_size = VEC[i].size; cur_el = VEC[i].el;
      {sp_chk_el3, sp_chk_el2, sp_chk_el1, sp_chk_el0} = VEC[i].en;
      @(negedge clk);
      if (VEC[i].exp == 2'b01) begin exp_fa = pc; exp_la = pc; end
      else if (VEC[i].exp != 2'b00) exp_fa = ad;
      chk($sformatf("R%0d vec%0d class", VEC[i].rq, i), {62'b0, fault_class}, {62'b0, VEC[i].exp});
      chk($sformatf("R%0d vec%0d fault", VEC[i].rq, i), {63'b0, fault}, {63'b0, VEC[i].exp != 2'b00});
      chk($sformatf("R%0d vec%0d fault_addr", VEC[i].rq, i), fault_addr, exp_fa);
      chk($sformatf("R%0d vec%0d link_addr", VEC[i].rq, i), link_addr, exp_la);
    end

    // R10: latency of one cycle and single-cycle pulse
    idle();
    @(negedge clk);
    fetch_valid = 1'b1; fetch_pc = 64'h0123_4567_89AB_CDEE;
    #1;
    chk("R10 not combinational", {63'b0, fault}, 64'h0);
    @(negedge clk);
    chk("R10 one cycle later", {63'b0, fault}, 64'h1);
    chk("R2 full pc in link_addr", link_addr, 64'h0123_4567_89AB_CDEE);
    chk("R2 full pc in fault_addr", fault_addr, 64'h0123_4567_89AB_CDEE);
    idle();
    @(negedge clk);
    chk("R10 pulse ends", {63'b0, fault}, 64'h0);
    chk("R10 fault_addr holds", fault_addr, 64'h0123_4567_89AB_CDEE);

    // R10: data fault replaces fault_addr, keeps link_addr
    data_valid = 1'b1; data_kind = 2'b11; data_size = 2'd2; data_addr = 64'hDEAD_BEEF_0000_0006;
    @(negedge clk);
    chk("R10 data fault addr", fault_addr, 64'hDEAD_BEEF_0000_0006);
    chk("R10 link unchanged", link_addr, 64'h0123_4567_89AB_CDEE);

    // R11: reset clears captured state
    idle();
    rst = 1'b1;
    @(negedge clk);
    chk("R11 reset clears fault_addr", fault_addr, 64'h0);
    chk("R11 reset clears link_addr", link_addr, 64'h0);
    rst = 1'b0;
    @(negedge clk);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule